// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block moves received Ethernet frame data from a word-wide receive FIFO into memory buffers described by a chain of descriptors. Each descriptor is four consecutive 32-bit words: a status word, a buffer length in bytes, a buffer address and the address of the next descriptor. The engine follows the next-descriptor pointer from one descriptor to the next. A frame that overruns one buffer continues in the next descriptor's buffer. The engine marks the opening and closing segments and records the frame length. It writes an optional timestamp and returns each descriptor to software by clearing its ownership bit.

Software writes the list into memory, sets the ownership bit of each descriptor it offers, and pulses start with the list base address. The engine then keeps one descriptor fetched ahead of the next frame. If it reads a descriptor that software still holds, it flags the condition and waits without moving from that list position. A poll demand resumes it. So does the arrival of a new frame, provided it was suspended between frames.

Top module: `rxDescDma`

## Requirements
- R1: Word 0 bit 31 is ownership (1 = engine). Every status write-back writes bit 31 as 0, after all other writes for that descriptor. Descriptor words are read at base+0 (status), +4 (length, bits SIZE_W-1:0), +8 (buffer address) and +12 (next descriptor address).
- R2: Each FIFO word is written to the next word address of the current buffer. A word is popped only in a cycle in which its memory write is granted.
- R3: A buffer whose byte length (a multiple of 4) is filled before the frame ends is closed with bit 8 clear and a length field of 0. The frame then continues at the start of the next descriptor's buffer.
- R4: Bit 9 is set only in the first descriptor of a frame and bit 8 only in the last. A single-descriptor frame has both set, and a middle descriptor has neither.
- R5: On the last descriptor, bits 29:16 of word 0 hold the frame length in bytes. The final FIFO word contributes fifoLastBytes bytes, with 0 meaning 4.
- R6: With tsEnable high at the frame's final word, words 2 and 3 of the last descriptor are written with tsLo and tsHi, or with all ones if tsValid is low. With tsEnable low those words are not written.
- R7: Closing the last descriptor of a frame sets status bit 6.
- R8: Reading a word 0 with bit 31 clear sets status bit 7 and suspends the engine. While suspended it makes no memory request.
- R9: After reset no memory request is made until startPulse, which fetches from listBase. A suspended engine refetches the same descriptor address on pollDemand, or on fifoValid when no frame is in progress.
- R10: Status bits are sticky. A 1 in statusClr clears the matching bit and leaves the other bits unchanged. All status bits are 0 after reset.
- R11: After closing a frame's last descriptor, the engine fetches the next descriptor without waiting for further FIFO data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| startPulse | input | 1 | Begin walking the list at listBase |
| listBase | input | 32 | Address of the first descriptor |
| pollDemand | input | 1 | Resume from suspension |
| tsEnable | input | 1 | Write timestamp into words 2 and 3 |
| tsValid | input | 1 | Timestamp for the current frame is valid |
| tsLo | input | 32 | Timestamp low word |
| tsHi | input | 32 | Timestamp high word |
| fifoValid | input | 1 | FIFO has a word |
| fifoData | input | 32 | FIFO word |
| fifoLast | input | 1 | Word is the frame's last |
| fifoLastBytes | input | 2 | Valid bytes in the last word, 0 = 4 |
| fifoPop | output | 1 | FIFO word consumed |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data |
| memGnt | input | 1 | Access completes this cycle |
| memRdata | input | 32 | Read data, valid with memGnt |
| statusClr | input | 8 | Write-one-to-clear for status |
| dmaStatus | output | 8 | Bit 6 frame received, bit 7 descriptor unavailable |

## Verification
The bench builds the engine with its default widths: a 13-bit buffer length and a 14-bit frame length field. It sets up a four-entry ring with buffer lengths of 64, 16, 24 and 64 bytes. These short buffers make frames span two and three descriptors, including a middle segment that carries neither marker bit. They also make the ring wrap several times within a short run. Grants are thinned by a shift-register pattern, so every state of the engine has to wait on the memory port. Suspension is triggered both between frames and by the ahead-fetch itself.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {SEL_W0, SEL_W1, SEL_W2, SEL_W3, SEL_BUF} addrSelT;

  typedef struct packed {
    logic    loadBase;
    logic    takeSize;
    logic    takeBuf;
    logic    takeNext;
    logic    advance;
    logic    beat;
    logic    newFrame;
    logic    latchTs;
    logic    wrFirst;
    logic    wrLast;
    addrSelT sel;
  } dpStrobeT;

  localparam int RI_BIT = 6;
  localparam int BU_BIT = 7;
endpackage

// File: rtl/rxdma_dpath.sv
module rxdma_dpath import rxdma_pkg::*; #(
  parameter int SIZE_W = 13,
  parameter int LEN_W  = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobeT    stb,
  input  logic [31:0] listBase,
  input  logic [31:0] memRdata,
  input  logic [31:0] fifoData,
  input  logic        fifoLast,
  input  logic [1:0]  fifoLastBytes,
  input  logic        tsValid,
  input  logic [31:0] tsLo,
  input  logic [31:0] tsHi,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic        bufEnds
);
  localparam int LEN_LSB = 16;
  localparam logic [SIZE_W-1:0] WORD_BYTES = SIZE_W'(4);

  logic [31:0]       descAddr, bufPtr, nextPtr, tsLoR, tsHiR;
  logic [SIZE_W-1:0] bufLeft;
  logic [LEN_W-1:0]  frameLen;
  logic              tsOkR;
  logic [2:0]        beatBytes;
  logic [31:0]       statusWord;

  assign beatBytes = (fifoLast && fifoLastBytes != 2'd0) ? {1'b0, fifoLastBytes} : 3'd4;
  assign bufEnds   = bufLeft <= WORD_BYTES;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr <= '0; bufPtr <= '0; nextPtr <= '0; bufLeft <= '0;
      frameLen <= '0; tsLoR <= '0; tsHiR <= '0; tsOkR <= 1'b0;
    end else begin
      if (stb.loadBase) descAddr <= listBase;
      if (stb.advance)  descAddr <= nextPtr;
      if (stb.takeSize) bufLeft  <= memRdata[SIZE_W-1:0];
      if (stb.takeBuf)  bufPtr   <= memRdata;
      if (stb.takeNext) nextPtr  <= memRdata;
      if (stb.newFrame) frameLen <= '0;
      if (stb.beat) begin
        bufPtr   <= bufPtr + 32'd4;
        bufLeft  <= bufLeft - WORD_BYTES;
        frameLen <= frameLen + LEN_W'(beatBytes);
      end
      if (stb.latchTs) begin
        tsLoR <= tsLo; tsHiR <= tsHi; tsOkR <= tsValid;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[LEN_LSB +: LEN_W] = stb.wrLast ? frameLen : '0;
    statusWord[9] = stb.wrFirst;
    statusWord[8] = stb.wrLast;
  end

  always_comb begin
    memAddr  = descAddr;
    memWdata = '0;
    case (stb.sel)
      SEL_W0:  memWdata = statusWord;
      SEL_W1:  memAddr  = descAddr + 32'd4;
      SEL_W2:  begin memAddr = descAddr + 32'd8;  memWdata = tsOkR ? tsLoR : '1; end
      SEL_W3:  begin memAddr = descAddr + 32'd12; memWdata = tsOkR ? tsHiR : '1; end
      SEL_BUF: begin memAddr = bufPtr; memWdata = fifoData; end
      default: memAddr = descAddr;
    endcase
  end

  AST_NO_BUF_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.beat |-> bufLeft >= WORD_BYTES); // R3
  AST_LEN_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beat && !stb.newFrame) |=> frameLen != $past(frameLen)); // R5
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl import rxdma_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       pollDemand,
  input  logic       tsEnable,
  input  logic       fifoValid,
  input  logic       fifoLast,
  input  logic       memGnt,
  input  logic       descOwned,
  input  logic       bufEnds,
  input  logic [7:0] statusClr,
  output logic       fifoPop,
  output logic       memReq,
  output logic       memWe,
  output dpStrobeT   stb,
  output logic [7:0] dmaStatus
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F1, ST_F2, ST_F3, ST_READY,
    ST_XFER, ST_TS2, ST_TS3, ST_CLOSE, ST_SUSP
  } stateT;

  stateT      st, stNext;
  logic       frameActive, segFirst, segLast;
  logic       setRi, setBu, lastBeat, fillBeat, closeDone, openFrame;
  logic [7:0] statR, setMask;

  always_comb begin
    stNext = st;
    stb = '0;
    memReq = 1'b0; memWe = 1'b0; fifoPop = 1'b0;
    setRi = 1'b0; setBu = 1'b0; lastBeat = 1'b0; fillBeat = 1'b0;
    closeDone = 1'b0; openFrame = 1'b0;
    case (st)
      ST_IDLE: if (startPulse) begin stb.loadBase = 1'b1; stNext = ST_F0; end
      ST_F0: begin
        memReq = 1'b1; stb.sel = SEL_W0;
        if (memGnt) begin
          if (descOwned) stNext = ST_F1;
          else begin setBu = 1'b1; stNext = ST_SUSP; end
        end
      end
      ST_F1: begin
        memReq = 1'b1; stb.sel = SEL_W1;
        if (memGnt) begin stb.takeSize = 1'b1; stNext = ST_F2; end
      end
      ST_F2: begin
        memReq = 1'b1; stb.sel = SEL_W2;
        if (memGnt) begin stb.takeBuf = 1'b1; stNext = ST_F3; end
      end
      ST_F3: begin
        memReq = 1'b1; stb.sel = SEL_W3;
        if (memGnt) begin stb.takeNext = 1'b1; stNext = ST_READY; end
      end
      ST_READY: if (fifoValid) begin
        openFrame = !frameActive;
        stb.newFrame = !frameActive;
        stNext = ST_XFER;
      end
      ST_XFER: begin
        memReq = fifoValid; memWe = 1'b1; stb.sel = SEL_BUF;
        if (memGnt && fifoValid) begin
          stb.beat = 1'b1; fifoPop = 1'b1;
          if (fifoLast) begin
            lastBeat = 1'b1; stb.latchTs = 1'b1;
            stNext = tsEnable ? ST_TS2 : ST_CLOSE;
          end else if (bufEnds) begin
            fillBeat = 1'b1; stNext = ST_CLOSE;
          end
        end
      end
      ST_TS2: begin
        memReq = 1'b1; memWe = 1'b1; stb.sel = SEL_W2;
        if (memGnt) stNext = ST_TS3;
      end
      ST_TS3: begin
        memReq = 1'b1; memWe = 1'b1; stb.sel = SEL_W3;
        if (memGnt) stNext = ST_CLOSE;
      end
      ST_CLOSE: begin
        memReq = 1'b1; memWe = 1'b1; stb.sel = SEL_W0;
        stb.wrFirst = segFirst; stb.wrLast = segLast;
        if (memGnt) begin
          closeDone = 1'b1; stb.advance = 1'b1; setRi = segLast;
          stNext = ST_F0;
        end
      end
      ST_SUSP: if (pollDemand || (fifoValid && !frameActive)) stNext = ST_F0;
      default: stNext = ST_IDLE;
    endcase
  end

  always_comb begin
    setMask = '0;
    setMask[RI_BIT] = setRi;
    setMask[BU_BIT] = setBu;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE; frameActive <= 1'b0; segFirst <= 1'b0; segLast <= 1'b0;
      statR <= '0;
    end else begin
      st <= stNext;
      statR <= (statR & ~statusClr) | setMask;
      if (openFrame) begin frameActive <= 1'b1; segFirst <= 1'b1; end
      else if (closeDone) begin
        segFirst <= 1'b0;
        if (segLast) frameActive <= 1'b0;
      end
      if (lastBeat) segLast <= 1'b1;
      else if (fillBeat || closeDone) segLast <= 1'b0;
    end
  end

  assign dmaStatus = statR;

  AST_POP_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (memReq && memWe && memGnt)); // R2
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SUSP) |-> !memReq); // R8
  AST_BU_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statR[BU_BIT]) |-> $past(st == ST_F0 && memGnt && !descOwned)); // R8
  AST_RI_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statR[RI_BIT]) |-> $past(st == ST_CLOSE && memGnt && segLast)); // R7
  AST_OWN_RETURNED: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CLOSE && memReq) |-> memWe); // R1
  AST_AHEAD_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CLOSE && memGnt) |=> (st == ST_F0 && memReq)); // R11
endmodule

// File: rtl/rxDescDma.sv
module rxDescDma import rxdma_pkg::*; #(
  parameter int SIZE_W = 13,
  parameter int LEN_W  = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic [31:0] listBase,
  input  logic        pollDemand,
  input  logic        tsEnable,
  input  logic        tsValid,
  input  logic [31:0] tsLo,
  input  logic [31:0] tsHi,
  input  logic        fifoValid,
  input  logic [31:0] fifoData,
  input  logic        fifoLast,
  input  logic [1:0]  fifoLastBytes,
  output logic        fifoPop,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memGnt,
  input  logic [31:0] memRdata,
  input  logic [7:0]  statusClr,
  output logic [7:0]  dmaStatus
);
  dpStrobeT stb;
  logic     bufEnds;

  rxdma_ctrl i_ctrl (
    .clk, .rstN, .startPulse, .pollDemand, .tsEnable, .fifoValid, .fifoLast,
    .memGnt, .descOwned(memRdata[31]), .bufEnds, .statusClr,
    .fifoPop, .memReq, .memWe, .stb, .dmaStatus
  );

  rxdma_dpath #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) i_dpath (
    .clk, .rstN, .stb, .listBase, .memRdata, .fifoData, .fifoLast,
    .fifoLastBytes, .tsValid, .tsLo, .tsHi, .memAddr, .memWdata, .bufEnds
  );
endmodule

// File: tb/test_rxDescDma.sv
module test_rxDescDma;
  logic clk = 1'b0, rstN = 1'b0;
  logic startPulse = 0, pollDemand = 0, tsEnable = 0, tsValid = 0;
  logic [31:0] listBase = '0, tsLo = '0, tsHi = '0;
  logic fifoValid = 0, fifoLast = 0, memGnt = 0;
  logic [31:0] fifoData = '0;
  logic [1:0] fifoLastBytes = '0;
  logic [7:0] statusClr = '0;
  logic fifoPop, memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [7:0] dmaStatus;

  rxDescDma i_rxDescDma (.*);

  always #4 clk = ~clk;

  logic [31:0] mem [0:255];
  assign memRdata = mem[memAddr[9:2]];

  typedef struct packed { logic [31:0] a; logic [31:0] d; logic [1:0] kind; } wrT;
  typedef struct packed { logic [31:0] d; logic l; logic [1:0] b; } fifoT;
  wrT   expQ[$];
  fifoT fifoQ[$];
  int checks = 0, fails = 0, cur = 0;
  int bufSize [4] = '{64, 16, 24, 64};
  logic pendPop = 0, gntAll = 1;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver of FIFO and memory, monitor of writes
  always @(negedge clk) begin
    if (pendPop && fifoQ.size() > 0) void'(fifoQ.pop_front());
    if (fifoQ.size() > 0) begin
      fifoValid = 1; fifoData = fifoQ[0].d; fifoLast = fifoQ[0].l; fifoLastBytes = fifoQ[0].b;
    end else begin
      fifoValid = 0; fifoLast = 0; fifoLastBytes = 0;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1;
    memGnt = memReq && (gntAll || lfsr[0] || lfsr[1]);
    if (memGnt && memWe) begin
      mem[memAddr[9:2]] = memWdata;
      if (expQ.size() == 0) chk(0, "R2 unexpected write", memAddr, 32'hx);
      else begin
        wrT e;
        e = expQ.pop_front();
        case (e.kind)
          2'd0: begin chk(memAddr == e.a, "R2 addr", memAddr, e.a); chk(memWdata == e.d, "R2 data", memWdata, e.d); end
          2'd1: begin chk(memAddr == e.a, "R1 status addr", memAddr, e.a); chk(memWdata == e.d, "R4 status word", memWdata, e.d); end
          default: begin chk(memAddr == e.a, "R6 ts addr", memAddr, e.a); chk(memWdata == e.d, "R6 ts data", memWdata, e.d); end
        endcase
      end
    end
    #1;
    pendPop = fifoPop;
  end

  task automatic rearm();
    for (int i = 0; i < 4; i++) begin
      mem[i*4]   = 32'h8000_0000;
      mem[i*4+1] = bufSize[i];
      mem[i*4+2] = 32'h100 + i*32'h40;
      mem[i*4+3] = ((i + 1) % 4) * 16;
    end
  endtask

  task automatic sendFrame(input int nBytes, input int seed);
    int off = 0;
    bit first = 1;
    int nWords = (nBytes + 3) / 4;
    for (int k = 0; k < nWords; k++) begin
      bit last = (k == nWords - 1);
      logic [31:0] d = 32'hA500_0000 + (seed << 8) + k;
      fifoQ.push_back({d, last, last ? 2'(nBytes % 4) : 2'd0});
      expQ.push_back({32'h100 + cur*32'h40 + off, d, 2'd0});
      off += 4;
      if (!last && off == bufSize[cur]) begin  // R3 split
        expQ.push_back({32'(cur*16), 32'(first) << 9, 2'd1});
        cur = (cur + 1) % 4; off = 0; first = 0;
      end
    end
    if (tsEnable) begin
      expQ.push_back({32'(cur*16 + 8),  tsValid ? tsLo : 32'hFFFF_FFFF, 2'd2});
      expQ.push_back({32'(cur*16 + 12), tsValid ? tsHi : 32'hFFFF_FFFF, 2'd2});
    end
    expQ.push_back({32'(cur*16), (32'(nBytes) << 16) | (32'(first) << 9) | 32'h100, 2'd1});
    cur = (cur + 1) % 4;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000 && (expQ.size() != 0 || fifoQ.size() != 0); i++) @(negedge clk);
    chk(expQ.size() == 0, "R2 writes outstanding", expQ.size(), 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic clearStatus(input logic [7:0] m);
    statusClr = m; @(negedge clk); statusClr = '0; @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rearm();
    repeat (3) @(negedge clk);
    rstN = 1;
    chk(dmaStatus == 8'h00, "R10 reset status", dmaStatus, 0);
    repeat (5) @(negedge clk);
    chk(memReq == 0, "R9 idle before start", memReq, 0);
    startPulse = 1; @(negedge clk); startPulse = 0;
    repeat (20) @(negedge clk);
    chk(memReq == 0 && dmaStatus == 0, "R11 holding fetched descriptor", {dmaStatus, 23'd0, memReq}, 0);

    sendFrame(20, 1); waitDone();                       // single descriptor, R4
    chk(dmaStatus[6] == 1, "R7 receive flag", dmaStatus, 8'h40);
    chk(mem[2] == 32'h100, "R6 ts disabled word2 kept", mem[2], 32'h100);
    repeat (10) @(negedge clk);
    chk(dmaStatus == 8'h40, "R10 sticky", dmaStatus, 8'h40);
    clearStatus(8'h40);
    chk(dmaStatus == 0, "R10 cleared", dmaStatus, 0);
    rearm();

    gntAll = 0;
    sendFrame(13, 2); waitDone(); rearm();              // R5 partial last word
    sendFrame(40, 3); waitDone(); rearm();              // R3 two segments
    tsEnable = 1; tsValid = 1; tsLo = 32'h1234_5678; tsHi = 32'h9ABC_DEF0;
    sendFrame(8, 4); waitDone(); rearm();               // R6 valid stamp
    tsValid = 0;
    sendFrame(48, 5); waitDone(); rearm();              // R6 all ones, R4 middle segment
    tsEnable = 0;
    clearStatus(8'hFF);

    // suspension between frames, resumed by poll (cur == 0 here)
    mem[1*4] = 32'h0;
    sendFrame(8, 6); waitDone();
    chk(dmaStatus == 8'hC0, "R8 R11 unavailable flag from ahead fetch", dmaStatus, 8'hC0);
    for (int i = 0; i < 10; i++) begin
      chk(memReq == 0, "R8 no request while suspended", memReq, 0);
      @(negedge clk);
    end
    clearStatus(8'h40);
    chk(dmaStatus == 8'h80, "R10 selective clear", dmaStatus, 8'h80);
    clearStatus(8'h80);
    rearm();
    pollDemand = 1; @(negedge clk); pollDemand = 0;
    repeat (20) @(negedge clk);
    sendFrame(12, 7); waitDone();                       // R9 same position via poll
    chk(dmaStatus == 8'h40, "R9 resumed without new stall", dmaStatus, 8'h40);
    clearStatus(8'hFF);

    // suspension resumed by a new frame (cur == 2 here)
    rearm(); mem[3*4] = 32'h0;
    sendFrame(4, 8); waitDone();
    chk(dmaStatus[7] == 1, "R8 second stall", dmaStatus, 8'hC0);
    clearStatus(8'hFF);
    rearm();
    sendFrame(4, 9); waitDone();                        // R9 resumed by frame arrival
    chk(dmaStatus == 8'h40, "R9 frame resumes engine", dmaStatus, 8'h40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule